// File: doc/BRIEF.md
# Compact 16-bit ALU with Condition Flags

This block is the arithmetic and logic stage of a small single-cycle 16-bit RISC core. Each cycle it gets a destination operand, a second operand, a 4-bit function code and a flag that says whether the instruction is in register form or immediate form. The second operand is a register value or an already formed immediate. The block returns the result combinationally in the same cycle. It also gives a write-back enable. The four condition flags (zero, negative, carry, overflow) are held in registers so that later conditional branches and carry-chained instructions can read them.

The block supports add, subtract, add and subtract with stored carry, four bitwise operations, compare, and single-bit logical and arithmetic right shifts. The two instruction forms put the operands in opposite order. In register form the destination is the left operand. In immediate form the immediate is the left operand, so subtract becomes a reverse subtract. Compare sets the flags but never writes a register. A left shift is not a function of its own; software performs it by adding a register to itself. The data width is a parameter and defaults to 16. Where a requirement says MSB, it means bit WIDTH-1, which is bit 15 at the default.

Top module: `alu16_core`

## Requirements
- R1: A synchronous active-high reset clears all four flags (Z, N, C, V) to 0 at the next rising clock edge.
- R2: When imm_form is 0, the left operand A is dst_val and the right operand B is src_val. The function codes are 0 add (A+B), 4 and (A&B), 5 or (A|B), 6 xor (A^B) and 7 andn (A&~B). The bitwise group is chosen by the low two bits of the code when the code is 4 to 7.
- R3: When imm_form is 1, the operands swap: A is src_val (the immediate) and B is dst_val. Function 1 therefore returns src_val - dst_val.
- R4: Function 1 (sub) and function 8 (cmp) both compute A + ~B + 1, taken modulo 2^WIDTH. The carry out is 1 exactly when no borrow occurs, that is, when A >= B as unsigned numbers. For cmp, the result output carries the same value as sub.
- R5: Function 2 (adc) computes A + B + C, and function 3 (sbc) computes A + ~B + C. In both cases C is the stored carry flag.
- R6: Function 9 (srl) and function 0xA (sra) shift dst_val right by one bit in both forms. srl fills the MSB with 0. sra repeats the old MSB. src_val has no effect on either shift.
- R7: wr_en is high exactly when en is 1 and the function code is one of 0 to 7, 9 or 0xA. It is low for cmp and for the codes 0xB to 0xF.
- R8: On a clock edge where en is 1 and the function code is valid (0 to 0xA), Z becomes 1 if the result is zero and N becomes the MSB of the result.
- R9: On such an edge, when the function is an adder function (0 to 3 or 8), C becomes the carry out of the adder. V becomes 1 when the adder result overflows as a signed number, meaning the two adder inputs have equal sign bits but the sum's sign differs.
- R10: The bitwise and shift functions (4 to 7, 9, 0xA) leave C and V unchanged.
- R11: When en is 0, or when the function code is 0xB to 0xF, all four flags keep their values. An invalid code also drives result to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; flags update on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the flags |
| en | input | 1 | A valid ALU instruction is executing this cycle |
| imm_form | input | 1 | 1 selects immediate-form operand order (imm op rd) |
| fn | input | 4 | Function code |
| dst_val | input | WIDTH | Destination register value |
| src_val | input | WIDTH | Source register value or formed immediate |
| result | output | WIDTH | Combinational result |
| wr_en | output | 1 | Write the result back to the destination register |
| flag_z | output | 1 | Stored zero flag |
| flag_n | output | 1 | Stored negative flag |
| flag_c | output | 1 | Stored carry flag (1 = no borrow on subtract) |
| flag_v | output | 1 | Stored signed-overflow flag |

## Verification
The assertions check on every cycle that flags stay put on idle or invalid cycles, that Z and N follow the result of the previous enabled instruction, that bitwise and shift functions keep C and V, and that compare never raises the write enable. Only the bench's scenarios can show the arithmetic values themselves: reverse-order immediate subtraction, the carry and borrow convention, carry chaining through adc and sbc, and signed overflow. The bench covers these by sweeping every function, form and operand pair at a 4-bit width, while the carry flag left by earlier instructions varies naturally. It also shows the reset state and the zero result produced by invalid codes.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [3:0] {
        FN_ADD  = 4'h0,
        FN_SUB  = 4'h1,
        FN_ADC  = 4'h2,
        FN_SBC  = 4'h3,
        FN_AND  = 4'h4,
        FN_OR   = 4'h5,
        FN_XOR  = 4'h6,
        FN_ANDN = 4'h7,
        FN_CMP  = 4'h8,
        FN_SRL  = 4'h9,
        FN_SRA  = 4'hA
    } alu_fn_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } alu_flags_t;

    localparam logic [3:0] FN_LAST = 4'hA;

    function automatic logic fn_valid(input logic [3:0] f);
        return f <= FN_LAST;
    endfunction

endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             invert_b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   full;

    always_comb begin
        b_eff  = invert_b_i ? ~b_i : b_i;
        full   = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin_i};
        sum_o  = full[MSB:0];
        cout_o = full[WIDTH];
        ovf_o  = (a_i[MSB] == b_eff[MSB]) && (full[MSB] != a_i[MSB]);
    end
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       sel_i,
    output logic [WIDTH-1:0] y_o
);
    always_comb begin
        unique case (sel_i)
            2'd0:    y_o = a_i & b_i;
            2'd1:    y_o = a_i | b_i;
            2'd2:    y_o = a_i ^ b_i;
            default: y_o = a_i & ~b_i;
        endcase
    end
endmodule

// File: rtl/alu16_shift.sv
module alu16_shift #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic             arith_i,
    output logic [WIDTH-1:0] y_o
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        y_o = {arith_i & x_i[MSB], x_i[MSB:1]};
    end
endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             imm_form,
    input  logic [3:0]       fn,
    input  logic [WIDTH-1:0] dst_val,
    input  logic [WIDTH-1:0] src_val,
    output logic [WIDTH-1:0] result,
    output logic             wr_en,
    output logic             flag_z,
    output logic             flag_n,
    output logic             flag_c,
    output logic             flag_v
);
    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        alu_flags_t flags;
    } core_state_t;

    core_state_t state_d, state_q;

    logic [WIDTH-1:0] opa, opb;
    logic             is_arith, is_logic, is_shift, is_valid;
    logic             inv_b, carry_in;
    logic [WIDTH-1:0] sum_y, logic_y, shift_y;
    logic             sum_c, sum_v;

    // Operand order and function-class decode
    always_comb begin
        opa      = imm_form ? src_val : dst_val;
        opb      = imm_form ? dst_val : src_val;
        is_valid = fn_valid(fn);
        is_arith = (fn <= FN_SBC) || (fn == FN_CMP);
        is_logic = (fn[3:2] == 2'b01);
        is_shift = (fn == FN_SRL) || (fn == FN_SRA);
        inv_b    = (fn == FN_SUB) || (fn == FN_SBC) || (fn == FN_CMP);
        unique case (fn)
            FN_ADC, FN_SBC: carry_in = state_q.flags.c;
            FN_SUB, FN_CMP: carry_in = 1'b1;
            default:        carry_in = 1'b0;
        endcase
    end

    alu16_addsub #(.WIDTH(WIDTH)) i_addsub (
        .a_i        (opa),
        .b_i        (opb),
        .invert_b_i (inv_b),
        .cin_i      (carry_in),
        .sum_o      (sum_y),
        .cout_o     (sum_c),
        .ovf_o      (sum_v)
    );

    alu16_logic #(.WIDTH(WIDTH)) i_logic (
        .a_i   (opa),
        .b_i   (opb),
        .sel_i (fn[1:0]),
        .y_o   (logic_y)
    );

    alu16_shift #(.WIDTH(WIDTH)) i_shift (
        .x_i     (dst_val),
        .arith_i (fn == FN_SRA),
        .y_o     (shift_y)
    );

    // Result selection, write enable, next flags
    always_comb begin
        if (is_arith)      result = sum_y;
        else if (is_logic) result = logic_y;
        else if (is_shift) result = shift_y;
        else               result = '0;

        wr_en = en && is_valid && (fn != FN_CMP);

        state_d = state_q;
        if (en && is_valid) begin
            state_d.flags.z = (result == '0);
            state_d.flags.n = result[MSB];
            if (is_arith) begin
                state_d.flags.c = sum_c;
                state_d.flags.v = sum_v;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign flag_z = state_q.flags.z;
    assign flag_n = state_q.flags.n;
    assign flag_c = state_q.flags.c;
    assign flag_v = state_q.flags.v;

    // R11
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en || fn > FN_LAST) |=> $stable({flag_z, flag_n, flag_c, flag_v}));

    // R8
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (en && fn <= FN_LAST) |=> (flag_z == ($past(result) == '0)));

    // R8
    neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (en && fn <= FN_LAST) |=> (flag_n == $past(result[MSB])));

    // R10
    cv_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (en && (fn[3:2] == 2'b01 || fn == FN_SRL || fn == FN_SRA))
        |=> $stable({flag_c, flag_v}));

    // R7
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (fn == FN_CMP || fn > FN_LAST) |-> !wr_en);

endmodule

// File: tb/test_alu16_core.sv
module test_alu16_core;
    localparam int W    = 4;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic         imm_form = 1'b0;
    logic [3:0]   fn = 4'h0;
    logic [W-1:0] dst_val = '0;
    logic [W-1:0] src_val = '0;
    logic [W-1:0] result;
    logic         wr_en;
    logic         flag_z, flag_n, flag_c, flag_v;

    int checks = 0;
    int fails  = 0;
    int ez = 0, en_f = 0, ec = 0, ev = 0;
    string flag_tag_zn = "R1";
    string flag_tag_cv = "R1";

    always #5 clk = ~clk;

    alu16_core #(.WIDTH(W)) i_alu16_core (
        .clk(clk), .rst(rst), .en(en), .imm_form(imm_form), .fn(fn),
        .dst_val(dst_val), .src_val(src_val), .result(result), .wr_en(wr_en),
        .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c), .flag_v(flag_v)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int sext(input int x);
        return (x & (1 << (W - 1))) ? x - (1 << W) : x;
    endfunction

    task automatic check_flags();
        chk(flag_tag_zn, "flag_z", int'(flag_z), ez);
        chk(flag_tag_zn, "flag_n", int'(flag_n), en_f);
        chk(flag_tag_cv, "flag_c", int'(flag_c), ec);
        chk(flag_tag_cv, "flag_v", int'(flag_v), ev);
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: flags cleared by reset
        check_flags();

        for (int f = 0; f < 16; f++)
            for (int m = 0; m < 2; m++)
                for (int x = 0; x < 16; x++)
                    for (int y = 0; y < 16; y++) begin
                        int a, b, bx, cin, r, s, sv, ev_en, wexp;
                        bit arith, lg, sh, valid;
                        string rtag;
                        @(negedge clk);
                        check_flags();
                        ev_en    = (((x * 3) + y + f) % 5) != 0;
                        en       = ev_en[0];
                        fn       = f[3:0];
                        imm_form = m[0];
                        dst_val  = x[W-1:0];
                        src_val  = y[W-1:0];
                        #1;
                        a     = m ? y : x;
                        b     = m ? x : y;
                        valid = f <= 10;
                        arith = (f <= 3) || (f == 8);
                        lg    = (f >= 4) && (f <= 7);
                        sh    = (f == 9) || (f == 10);
                        bx    = (f == 1 || f == 3 || f == 8) ? (~b & MASK) : b;
                        cin   = (f == 1 || f == 8) ? 1 : ((f == 2 || f == 3) ? ec : 0);
                        s     = a + bx + cin;
                        sv    = sext(a) + sext(bx) + cin;
                        if (arith)        r = s & MASK;
                        else if (f == 4)  r = a & b;
                        else if (f == 5)  r = a | b;
                        else if (f == 6)  r = a ^ b;
                        else if (f == 7)  r = a & ~b & MASK;
                        else if (f == 9)  r = x >> 1;
                        else if (f == 10) r = (x >> 1) | (x & (1 << (W - 1)));
                        else              r = 0;
                        if (sh)                      rtag = "R6";
                        else if (f == 2 || f == 3)   rtag = "R5";
                        else if (f == 1 || f == 8)   rtag = "R4";
                        else if (!valid)             rtag = "R11";
                        else if (m == 1)             rtag = "R3";
                        else                         rtag = "R2";
                        chk(rtag, "result", int'(result), r);
                        wexp = (ev_en != 0 && valid && f != 8) ? 1 : 0;
                        chk("R7", "wr_en", int'(wr_en), wexp);
                        if (ev_en != 0 && valid) begin
                            ez   = (r == 0) ? 1 : 0;
                            en_f = (r >> (W - 1)) & 1;
                            flag_tag_zn = "R8";
                            if (arith) begin
                                ec = (s >> W) & 1;
                                ev = (sv > (MASK >> 1) || sv < -((MASK >> 1) + 1)) ? 1 : 0;
                                flag_tag_cv = "R9";
                            end else begin
                                flag_tag_cv = "R10";
                            end
                        end else begin
                            flag_tag_zn = "R11";
                            flag_tag_cv = "R11";
                        end
                    end
        @(negedge clk);
        check_flags();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule